// File: doc/BRIEF.md
# Parallel Byte Slave Port

This block lets an external processor trade single bytes with local firmware over an asynchronous, active-low bus. The bus has a chip select, a read strobe and a write strobe. One 8-bit data path runs in each direction. A byte that the external side writes lands in an input latch, which firmware then reads. A byte that firmware writes lands in an output latch, which the external side reads through a shared bus. The pad driver for that shared bus is represented by an output-enable signal.

The three strobes pass through a two-stage synchronizer. The block then works out transfer boundaries from the synchronized levels. A free-running four-phase sequence (Q1 to Q4) times the completion flags. When a transfer ends, the block waits for the next Q2 phase and raises its flags in the Q4 phase that follows.

Firmware sees four status bits: input full, output full, input overflow and transfer done. It has pulse inputs to read the input latch, write the output latch, clear the overflow flag and clear the done flag. A mode enable switches the port function on. An interrupt-enable input gates the done flag onto the interrupt request line.

Top module: `pslave_port`

## Requirements
- R1: A bus write runs while the synchronized chip select and write strobe are both low. It completes when either of them goes high. Completion sets `st_in_full` and `st_done`, both at the first Q4 phase that comes after the next Q2 phase. They are set no earlier than 5 and no later than 8 clock edges after the first edge that samples the release.
- R2: `st_in_full` clears only on a firmware read pulse `fw_rd_in` or when the mode is off. If a write completion and a read pulse arrive together, the flag stays set.
- R3: `st_ovf` sets when a write completion arrives while `st_in_full` is already set. It stays set until `fw_clr_ovf` is pulsed. A read pulse does not clear it, and neither does turning the mode off.
- R4: A bus read starts when the synchronized chip select and read strobe are both first seen low. `st_out_full` clears on the clock edge right after that start is detected.
- R5: A bus read completes when either strobe goes high. Completion sets `st_done` at the first Q4 phase after the next Q2 phase.
- R6: A firmware write pulse `fw_wr_out` loads `fw_wdata` into the output latch and sets `st_out_full`. The flag stays set until a bus read starts. If the write pulse and a read start arrive together, the write wins.
- R7: While `fw_mode_en` is low, `st_in_full` and `st_out_full` read 0 one edge later. A bus transfer made while the mode is low sets no flag.
- R8: `st_done` stays set until `fw_clr_done` is pulsed. A new completion arriving together with the clear wins. `irq` equals `st_done` AND `fw_irq_en`.
- R9: `bus_oe` is high exactly while `fw_mode_en` is high and the raw `bus_cs_n` and `bus_rd_n` are both low. `bus_dout` always presents the output latch.
- R10: While a bus write is active and the mode is on, the input latch follows `bus_din`. After the write, `fw_rdata` holds the last byte presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | External chip select, active low |
| bus_rd_n | input | 1 | External read strobe, active low |
| bus_wr_n | input | 1 | External write strobe, active low |
| bus_din | input | DATA_W | Byte driven by the external processor |
| bus_dout | output | DATA_W | Output latch value toward the pads |
| bus_oe | output | 1 | Pad output enable for the shared bus |
| fw_mode_en | input | 1 | Port mode enable |
| fw_irq_en | input | 1 | Interrupt enable |
| fw_wr_out | input | 1 | Pulse: load the output latch |
| fw_wdata | input | DATA_W | Byte firmware places in the output latch |
| fw_rd_in | input | 1 | Pulse: firmware takes the input latch |
| fw_rdata | output | DATA_W | Input latch contents |
| fw_clr_ovf | input | 1 | Pulse: clear the overflow flag |
| fw_clr_done | input | 1 | Pulse: clear the transfer-done flag |
| st_in_full | output | 1 | Input latch holds an unread byte |
| st_out_full | output | 1 | Output latch not yet taken by the bus |
| st_ovf | output | 1 | Bus write arrived over an unread byte |
| st_done | output | 1 | Transfer-done flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that firmware pulses last one clock. They also assume the external side holds each strobe level long enough for the synchronizer to see it: at least three clock cycles low and at least three high. The bench drives every strobe change on the falling clock edge. It holds each level for several cycles and waits well past the worst-case Q2-to-Q4 delay before it starts the next transfer. Firmware pulses are single-cycle and driven away from the active edge.

// File: rtl/pport_pkg.sv
// Shared types for the parallel byte slave port.
// Assumes nothing beyond a two-bit phase encoding where Q1..Q4 = 0..3.
package pport_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        DN_IDLE    = 2'd0,
        DN_WAIT_Q2 = 2'd1,
        DN_WAIT_Q4 = 2'd2
    } done_st_t;

endpackage

// File: rtl/pport_sync.sv
// Multi-stage synchronizer for idle-high asynchronous strobes.
// Assumes every input idles high; all stages reset to ones.
module pport_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                // Later stages shift the previous stage on.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '1;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pport_phase.sv
// Free-running four-phase sequencer, Q1 after reset, advancing each clock.
// Assumes the block clock is the phase clock.
module pport_phase
    import pport_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);

    logic [1:0] cnt_q;

    // Advance the phase count by one every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= 2'd0;
        else        cnt_q <= cnt_q + 2'd1;
    end

    assign phase = phase_t'(cnt_q);

endmodule

// File: rtl/pport_done.sv
// Completion timer: after a trigger, waits for the next Q2 phase and
// fires during the Q4 phase that follows. A new trigger restarts the wait.
// Assumes trigger is a single-cycle pulse.
module pport_done
    import pport_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  logic   trigger,
    output logic   fire
);

    done_st_t st_q, st_d;

    // Next-state selection for the completion timer.
    always_comb begin
        st_d = st_q;
        if (trigger) begin
            st_d = DN_WAIT_Q2;
        end else begin
            case (st_q)
                DN_WAIT_Q2: if (phase == PH_Q2) st_d = DN_WAIT_Q4;
                DN_WAIT_Q4: if (phase == PH_Q4) st_d = DN_IDLE;
                default:    st_d = DN_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DN_IDLE;
        else        st_q <= st_d;
    end

    assign fire = (st_q == DN_WAIT_Q4) && (phase == PH_Q4);

    // R1 / R5: a Q4 wait is reached only after a Q2 phase was seen
    p_q2_before_q4_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DN_WAIT_Q4 && $past(st_q) == DN_WAIT_Q2) |-> $past(phase) == PH_Q2);

endmodule

// File: rtl/pslave_port.sv
// Parallel byte slave port: an external processor writes an input latch and
// reads an output latch over active-low chip select / read / write strobes;
// firmware sees full, overflow and transfer-done flags.
// Assumes strobes hold each level for at least three clocks and firmware
// pulses last one clock.
module pslave_port
    import pport_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic              fw_mode_en,
    input  logic              fw_irq_en,
    input  logic              fw_wr_out,
    input  logic [DATA_W-1:0] fw_wdata,
    input  logic              fw_rd_in,
    output logic [DATA_W-1:0] fw_rdata,
    input  logic              fw_clr_ovf,
    input  logic              fw_clr_done,
    output logic              st_in_full,
    output logic              st_out_full,
    output logic              st_ovf,
    output logic              st_done,
    output logic              irq
);

    localparam int NSTROBE = 3;

    logic [NSTROBE-1:0] strobe_sync;
    logic               s_cs_n, s_rd_n, s_wr_n;
    logic               wr_lvl, rd_lvl, wr_lvl_q, rd_lvl_q;
    logic               wr_trig, rd_trig, rd_start;
    logic               wr_fire, rd_fire;
    phase_t             phase;

    logic [DATA_W-1:0]  in_latch_q, out_latch_q;
    logic               in_full_q, out_full_q, ovf_q, done_q;

    pport_sync #(.WIDTH(NSTROBE), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_cs_n, bus_rd_n, bus_wr_n}),
        .sync_out (strobe_sync)
    );

    assign {s_cs_n, s_rd_n, s_wr_n} = strobe_sync;

    pport_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    // Decode active transfer levels from synchronized strobes.
    assign wr_lvl = !s_cs_n && !s_wr_n;
    assign rd_lvl = !s_cs_n && !s_rd_n;

    // Remember the previous levels for start/end detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lvl_q <= 1'b0;
            rd_lvl_q <= 1'b0;
        end else begin
            wr_lvl_q <= wr_lvl;
            rd_lvl_q <= rd_lvl;
        end
    end

    assign wr_trig  = fw_mode_en && wr_lvl_q && !wr_lvl;
    assign rd_trig  = fw_mode_en && rd_lvl_q && !rd_lvl;
    assign rd_start = fw_mode_en && rd_lvl && !rd_lvl_q;

    pport_done u_wr_done (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .trigger (wr_trig),
        .fire    (wr_fire)
    );

    pport_done u_rd_done (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .trigger (rd_trig),
        .fire    (rd_fire)
    );

    // Input latch follows the bus while a write is active.
    always_ff @(posedge clk) begin
        if (!rst_n)                   in_latch_q <= '0;
        else if (fw_mode_en && wr_lvl) in_latch_q <= bus_din;
    end

    // Output latch loads on a firmware write.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_latch_q <= '0;
        else if (fw_wr_out) out_latch_q <= fw_wdata;
    end

    // Input-full flag: set on write completion, cleared by firmware read.
    always_ff @(posedge clk) begin
        if (!rst_n || !fw_mode_en) in_full_q <= 1'b0;
        else if (wr_fire)          in_full_q <= 1'b1;
        else if (fw_rd_in)         in_full_q <= 1'b0;
    end

    // Output-full flag: set by firmware write, cleared at bus read start.
    always_ff @(posedge clk) begin
        if (!rst_n || !fw_mode_en) out_full_q <= 1'b0;
        else if (fw_wr_out)        out_full_q <= 1'b1;
        else if (rd_start)         out_full_q <= 1'b0;
    end

    // Overflow flag: sticky until firmware clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf_q <= 1'b0;
        else if (wr_fire && in_full_q) ovf_q <= 1'b1;
        else if (fw_clr_ovf)         ovf_q <= 1'b0;
    end

    // Transfer-done flag: set at Q4 after either completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                 done_q <= 1'b0;
        else if (wr_fire || rd_fire) done_q <= 1'b1;
        else if (fw_clr_done)       done_q <= 1'b0;
    end

    assign bus_oe      = fw_mode_en && !bus_cs_n && !bus_rd_n;
    assign bus_dout    = out_latch_q;
    assign fw_rdata    = in_latch_q;
    assign st_in_full  = in_full_q;
    assign st_out_full = out_full_q;
    assign st_ovf      = ovf_q;
    assign st_done     = done_q;
    assign irq         = done_q && fw_irq_en;

    // R1 / R5: flags only rise on an edge that sampled phase Q4
    p_done_on_q4_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(phase) == PH_Q4);

    p_full_on_q4_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full_q) |-> $past(phase) == PH_Q4);

    // R2: input-full drops only on a firmware read or with the mode off
    p_in_full_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_full_q) |-> ($past(fw_rd_in) || !$past(fw_mode_en)));

    // R3: overflow drops only on explicit clear
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_q) |-> $past(fw_clr_ovf));

    // R4: output-full drops only when a bus read starts or the mode is off
    p_out_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_full_q) |-> ($past(rd_lvl) || !$past(fw_mode_en)));

    // R6: output-full rises only after a firmware write
    p_out_full_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_full_q) |-> $past(fw_wr_out));

    // R7: mode off empties both buffers on the next edge
    p_mode_off_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fw_mode_en |=> (!in_full_q && !out_full_q));

    // R8: done flag drops only on an explicit clear
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_q) |-> $past(fw_clr_done));

endmodule

// File: tb/pslave_port_bench.sv
module pslave_port_bench;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_cs_n, bus_rd_n, bus_wr_n;
    logic [DW-1:0] bus_din, bus_dout, fw_wdata, fw_rdata;
    logic          bus_oe, fw_mode_en, fw_irq_en, fw_wr_out, fw_rd_in;
    logic          fw_clr_ovf, fw_clr_done;
    logic          st_in_full, st_out_full, st_ovf, st_done, irq;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pslave_port #(.DATA_W(DW)) u_pslave_port (
        .clk(clk), .rst_n(rst_n),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .fw_mode_en(fw_mode_en), .fw_irq_en(fw_irq_en),
        .fw_wr_out(fw_wr_out), .fw_wdata(fw_wdata),
        .fw_rd_in(fw_rd_in), .fw_rdata(fw_rdata),
        .fw_clr_ovf(fw_clr_ovf), .fw_clr_done(fw_clr_done),
        .st_in_full(st_in_full), .st_out_full(st_out_full),
        .st_ovf(st_ovf), .st_done(st_done), .irq(irq)
    );

    // Vector: bit 8 = direction (0 bus write, 1 bus read), bits 7:0 = byte
    localparam logic [8:0] VEC [8] = '{
        9'h0A5, 9'h15A, 9'h000, 9'h1FF,
        9'h0FF, 9'h100, 9'h03C, 9'h1C3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fw_pulse_rd();
        @(negedge clk) fw_rd_in = 1'b1;
        @(negedge clk) fw_rd_in = 1'b0;
    endtask

    task automatic fw_pulse_wr(input logic [DW-1:0] d);
        @(negedge clk) begin fw_wr_out = 1'b1; fw_wdata = d; end
        @(negedge clk) fw_wr_out = 1'b0;
    endtask

    task automatic fw_pulse_clr_done();
        @(negedge clk) fw_clr_done = 1'b1;
        @(negedge clk) fw_clr_done = 1'b0;
    endtask

    task automatic fw_pulse_clr_ovf();
        @(negedge clk) fw_clr_ovf = 1'b1;
        @(negedge clk) fw_clr_ovf = 1'b0;
    endtask

    // Bus write; returns after the latest flag-set edge has passed.
    task automatic bus_write(input logic [DW-1:0] d, input bit timing_chk);
        @(negedge clk) begin bus_din = d; bus_cs_n = 1'b0; bus_wr_n = 1'b0; end
        idle(5);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        if (timing_chk) chk("R1 done not before 5th edge", st_done, 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_read_start();
        @(negedge clk) begin bus_cs_n = 1'b0; bus_rd_n = 1'b0; end
    endtask

    task automatic bus_read_end();
        @(negedge clk) begin bus_cs_n = 1'b1; bus_rd_n = 1'b1; end
        repeat (9) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_din = '0;
        fw_mode_en = 1'b1; fw_irq_en = 1'b1; fw_wr_out = 1'b0; fw_wdata = '0;
        fw_rd_in = 1'b0; fw_clr_ovf = 1'b0; fw_clr_done = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // Reset state
        chk("R7 reset in_full", st_in_full, 0);
        chk("R7 reset out_full", st_out_full, 0);
        chk("R3 reset ovf", st_ovf, 0);
        chk("R8 reset done", st_done, 0);
        chk("R9 reset oe", bus_oe, 0);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            logic [DW-1:0] d;
            d = VEC[i][7:0];
            if (!VEC[i][8]) begin
                bus_write(d, 1'b1);
                chk("R1 in_full after write", st_in_full, 1);
                chk("R1 done after write", st_done, 1);
                chk("R10 input latch byte", fw_rdata, d);
                fw_pulse_rd();
                chk("R2 in_full cleared by read", st_in_full, 0);
                chk("R3 no ovf on single write", st_ovf, 0);
            end else begin
                fw_pulse_wr(d);
                chk("R6 out_full after fw write", st_out_full, 1);
                bus_read_start();
                #1 chk("R9 oe while reading", bus_oe, 1);
                chk("R9 dout byte", bus_dout, d);
                chk("R6 out_full held before sync", st_out_full, 1);
                idle(3);
                chk("R4 out_full cleared on read start", st_out_full, 0);
                chk("R5 done not yet set", st_done, 0);
                bus_read_end();
                chk("R5 done after read", st_done, 1);
                chk("R6 out_full stays low", st_out_full, 0);
                chk("R9 oe released", bus_oe, 0);
            end
            fw_pulse_clr_done();
            chk("R8 done cleared", st_done, 0);
        end

        // R8: stickiness and interrupt gating
        fw_irq_en = 1'b0;
        bus_write(8'h11, 1'b0);
        chk("R8 irq gated off", irq, 0);
        idle(20);
        chk("R8 done sticky", st_done, 1);
        fw_irq_en = 1'b1;
        #1 chk("R8 irq with enable", irq, 1);
        fw_pulse_clr_done();
        chk("R8 irq after clear", irq, 0);

        // R3: second write while full sets overflow
        bus_write(8'h22, 1'b0);
        chk("R3 overflow set", st_ovf, 1);
        chk("R10 latest byte kept", fw_rdata, 8'h22);
        fw_pulse_rd();
        chk("R3 ovf survives read", st_ovf, 1);
        chk("R2 in_full cleared", st_in_full, 0);

        // R7: mode off keeps buffers empty, ovf retained, no flags from bus
        fw_pulse_clr_done();
        fw_mode_en = 1'b0;
        fw_pulse_wr(8'h77);
        chk("R7 out_full held low", st_out_full, 0);
        bus_write(8'h33, 1'b0);
        chk("R7 in_full held low", st_in_full, 0);
        chk("R7 no done while off", st_done, 0);
        chk("R3 ovf kept with mode off", st_ovf, 1);
        chk("R10 latch ignores bus when off", fw_rdata, 8'h22);
        bus_read_start();
        #1 chk("R9 no oe with mode off", bus_oe, 0);
        bus_read_end();
        fw_mode_en = 1'b1;
        fw_pulse_clr_ovf();
        chk("R3 ovf cleared by firmware", st_ovf, 0);

        // R7: turning mode off while full empties the input buffer
        bus_write(8'h44, 1'b0);
        chk("R1 full before mode off", st_in_full, 1);
        fw_mode_en = 1'b0;
        idle(1);
        chk("R7 in_full dropped", st_in_full, 0);
        fw_mode_en = 1'b1;
        fw_pulse_clr_done();

        // R9: chip select alone does not enable the bus driver
        @(negedge clk) bus_cs_n = 1'b0;
        #1 chk("R9 no oe without rd", bus_oe, 0);
        @(negedge clk) bus_cs_n = 1'b1;
        idle(10);
        chk("R5 cs alone no done", st_done, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule